// File: doc/BRIEF.md
# ATA Host Register and Multiword DMA Cycle Sequencer

This block sits on the host side of one parallel ATA channel and turns simple requests into correctly sequenced bus cycles. A register request carries a read/write flag, a block choice (command block or control block), a 3-bit register offset and a 16-bit write word. The block drives the two block selects, the offset lines, the read or write strobe and the data bus enable, and it returns the read word with a one-cycle done pulse. A DMA request carries a direction and a word count. The block then marks each data cycle with the DMA acknowledge instead of the selects, and it starts each word only while the device requests DMA.

Every word cycle runs through the same named states. `S_IDLE` waits for work. `S_SETUP` holds the address and select for the setup count. `S_STROBE` holds the strobe low for at least the active count, and for longer while the synchronised device-ready input is low. `S_RECOVER` holds the strobe high for the recovery count. `S_GAP` holds the DMA acknowledge between DMA words. The transitions are:
- `S_IDLE→S_SETUP` accepts a register request.
- `S_IDLE→S_GAP` accepts a DMA start with a nonzero count.
- `S_GAP→S_SETUP` fires when the DMA request is high.
- `S_SETUP→S_STROBE` fires when the setup count expires.
- `S_STROBE→S_RECOVER` fires when the minimum width has passed and ready is high, or when the wait limit expires.
- `S_RECOVER→S_IDLE` ends a register cycle, the last DMA word or an errored word.
- `S_RECOVER→S_GAP` fires when DMA words remain.

The data bus is split into separate in, out and output-enable signals, and the chip pad joins them into one tri-state bus.

Top module: `ata_cycle_seq`

## Requirements
- R1: After reset, both selects, both strobes and the DMA acknowledge are high (inactive), `ata_d_oe` and `rsp_done` are 0, and `req_ready` is 1.
- R2: For a register cycle, `req_ctrl`=0 drives `ata_cmdsel_n` low and `req_ctrl`=1 drives `ata_ctlsel_n` low. Only one select is low at a time, and neither is low together with `ata_dack_n`. `ata_reg_a` equals the request offset and stays unchanged from the first setup cycle to the last recovery cycle. The select is high again in the cycle where `rsp_done` is high.
- R3: With ready high, the setup phase lasts max(`cfg_t1`,1) cycles, the strobe lasts max(`cfg_t2`,1) cycles and recovery lasts max(`cfg_t2i`,1) cycles. Reads use `ata_rd_n` and writes use `ata_wr_n`, and the two are never low together.
- R4: `rsp_done` is high for exactly one cycle, the first idle cycle after recovery. On a read, `rsp_rdata` then holds the value `ata_d_i` had in the last cycle in which the strobe was low.
- R5: On a write, `ata_d_oe` is high from the first setup cycle through the first recovery cycle, and `ata_d_o` carries the write word. On a read, `ata_d_oe` stays 0.
- R6: `ata_ready` passes through a two-flop synchroniser. A low level that is first seen from the strobe's first cycle, and is released in strobe cycle r (counted from 0), gives a strobe width of max(max(`cfg_t2`,1), r+3).
- R7: If ready stays low, the strobe ends after max(`cfg_t2`,1)+WAIT_LIMIT−1 cycles and `rsp_err` is 1 together with that `rsp_done`. Otherwise `rsp_err` is 0 with `rsp_done`.
- R8: A DMA start with count N>0 drives `ata_dack_n` low from the next cycle. It runs exactly N strobe cycles, with both selects high and one `rsp_done` per word, and `ata_dack_n` is high in the cycle of the last `rsp_done`. Read words are returned as in R4.
- R9: A DMA word begins only when `ata_dreq` is high at the end of an `S_GAP` cycle. While `ata_dreq` is low between words, no strobe occurs and `ata_dack_n` stays low.
- R10: A DMA start with count 0 is ignored: `ata_dack_n` and both strobes stay high and `req_ready` stays 1.
- R11: Requests are accepted only in idle (`req_ready`=1), and requests made while busy have no effect. When a register request and a DMA start arrive in the same idle cycle, the register request wins and the DMA start is dropped.
- R12: For DMA writes, each word's data is `req_wdata` as sampled at the clock edge that leaves `S_GAP` for that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_t1 | input | CNT_W | Setup phase length in cycles |
| cfg_t2 | input | CNT_W | Minimum strobe length in cycles |
| cfg_t2i | input | CNT_W | Recovery phase length in cycles |
| req_valid | input | 1 | Register cycle request |
| req_write | input | 1 | 1 = register write, 0 = read |
| req_ctrl | input | 1 | 0 = command block, 1 = control block |
| req_addr | input | ADDR_W | Register offset within the block |
| req_wdata | input | DATA_W | Write word (register and DMA writes) |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| dma_start | input | 1 | Start a DMA burst |
| dma_write | input | 1 | 1 = DMA to device, 0 = from device |
| dma_words | input | WORDS_W | Number of words in the burst |
| rsp_done | output | 1 | One-cycle pulse at the end of each word cycle |
| rsp_err | output | 1 | Ready wait limit reached, valid with rsp_done |
| rsp_rdata | output | DATA_W | Read word, valid with rsp_done |
| ata_cmdsel_n | output | 1 | Command block select, active low |
| ata_ctlsel_n | output | 1 | Control block select, active low |
| ata_reg_a | output | ADDR_W | Register offset lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dack_n | output | 1 | DMA acknowledge, active low |
| ata_dreq | input | 1 | Device DMA request |
| ata_ready | input | 1 | Device ready, low stretches the strobe |
| ata_d_i | input | DATA_W | Data bus input from pad |
| ata_d_o | output | DATA_W | Data bus output to pad |
| ata_d_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the sequencer with CNT_W=3, WAIT_LIMIT=6 and WORDS_W=4. With these values it can sweep every combination of setup, strobe and recovery counts from 0 to 3 for both reads and writes. The ready-release point is swept far enough to cross the short wait limit, so both the stretch formula and the timeout path are reached in a few cycles. Small word counts make DMA bursts with a mid-burst request pause cheap to run in full.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_STROBE,
        S_RECOVER,
        S_GAP
    } seq_state_e;

    typedef struct packed {
        logic       write;
        logic       ctrl;
        logic       dma;
    } cyc_kind_t;

endpackage

// File: rtl/ata_sync_chain.sv
module ata_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ata_wait_timer.sv
module ata_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + CW'(1);
        else          cnt_q <= '0;
    end

    assign hit = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ata_cycle_seq.sv
module ata_cycle_seq
    import ata_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int CNT_W       = 4,
    parameter int WORDS_W     = 8,
    parameter int WAIT_LIMIT  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_t1,
    input  logic [CNT_W-1:0]   cfg_t2,
    input  logic [CNT_W-1:0]   cfg_t2i,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_ctrl,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    input  logic               dma_start,
    input  logic               dma_write,
    input  logic [WORDS_W-1:0] dma_words,
    output logic               rsp_done,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               ata_cmdsel_n,
    output logic               ata_ctlsel_n,
    output logic [ADDR_W-1:0]  ata_reg_a,
    output logic               ata_rd_n,
    output logic               ata_wr_n,
    output logic               ata_dack_n,
    input  logic               ata_dreq,
    input  logic               ata_ready,
    input  logic [DATA_W-1:0]  ata_d_i,
    output logic [DATA_W-1:0]  ata_d_o,
    output logic               ata_d_oe
);

    seq_state_e           state_q, state_d;
    cyc_kind_t            kind_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [WORDS_W-1:0]   words_q;
    logic                 hold_q;
    logic                 cyc_err_q;
    logic                 done_q;
    logic                 err_q;

    logic                 rdy_s;
    logic                 ph_expired;
    logic                 ph_load;
    logic [CNT_W-1:0]     ph_val;
    logic                 wait_run;
    logic                 wait_hit;
    logic                 take_pio;
    logic                 take_dma;
    logic                 last_word;

    function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    ata_sync_chain #(.STAGES(SYNC_STAGES)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ata_ready),
        .q     (rdy_s)
    );

    ata_phase_timer #(.W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .expired  (ph_expired)
    );

    ata_wait_timer #(.LIMIT(WAIT_LIMIT)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wait_run),
        .hit   (wait_hit)
    );

    assign take_pio  = req_valid;
    assign take_dma  = !req_valid && dma_start && (dma_words != '0);
    assign wait_run  = (state_q == S_STROBE) && ph_expired && !rdy_s;
    assign last_word = (words_q == WORDS_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take_pio)      state_d = S_SETUP;
                else if (take_dma) state_d = S_GAP;
            end
            S_GAP: begin
                if (ata_dreq) state_d = S_SETUP;
            end
            S_SETUP: begin
                if (ph_expired) state_d = S_STROBE;
            end
            S_STROBE: begin
                if (ph_expired && rdy_s) state_d = S_RECOVER;
                else if (wait_hit)       state_d = S_RECOVER;
            end
            S_RECOVER: begin
                if (ph_expired) begin
                    if (!kind_q.dma || cyc_err_q || last_word) state_d = S_IDLE;
                    else                                       state_d = S_GAP;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // phase timer reload on entry to a timed phase
    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        if (state_d != state_q) begin
            unique case (state_d)
                S_SETUP:   begin ph_load = 1'b1; ph_val = len_m1(cfg_t1);  end
                S_STROBE:  begin ph_load = 1'b1; ph_val = len_m1(cfg_t2);  end
                S_RECOVER: begin ph_load = 1'b1; ph_val = len_m1(cfg_t2i); end
                default:   begin ph_load = 1'b0; ph_val = '0;              end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // cycle context and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            words_q   <= '0;
            hold_q    <= 1'b0;
            cyc_err_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            hold_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (take_pio) begin
                        kind_q    <= '{write: req_write, ctrl: req_ctrl, dma: 1'b0};
                        addr_q    <= req_addr;
                        wdata_q   <= req_wdata;
                        cyc_err_q <= 1'b0;
                    end else if (take_dma) begin
                        kind_q  <= '{write: dma_write, ctrl: 1'b0, dma: 1'b1};
                        addr_q  <= '0;
                        words_q <= dma_words;
                    end
                end
                S_GAP: begin
                    if (ata_dreq) begin
                        wdata_q   <= req_wdata;
                        cyc_err_q <= 1'b0;
                    end
                end
                S_SETUP: begin
                end
                S_STROBE: begin
                    if (state_d == S_RECOVER) begin
                        hold_q <= 1'b1;
                        if (!kind_q.write) rdata_q <= ata_d_i;
                        if (!(ph_expired && rdy_s)) cyc_err_q <= 1'b1;
                    end
                end
                S_RECOVER: begin
                    if (ph_expired) begin
                        done_q <= 1'b1;
                        err_q  <= cyc_err_q;
                        if (kind_q.dma) begin
                            if (cyc_err_q) words_q <= '0;
                            else           words_q <= words_q - WORDS_W'(1);
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // bus outputs decoded from state
    always_comb begin
        logic in_cyc;
        logic sel;
        in_cyc       = (state_q == S_SETUP) || (state_q == S_STROBE) ||
                       (state_q == S_RECOVER);
        sel          = in_cyc && !kind_q.dma;
        ata_cmdsel_n = !(sel && !kind_q.ctrl);
        ata_ctlsel_n = !(sel && kind_q.ctrl);
        ata_reg_a    = sel ? addr_q : '0;
        ata_dack_n   = !(kind_q.dma && (in_cyc || (state_q == S_GAP)));
        ata_rd_n     = !((state_q == S_STROBE) && !kind_q.write);
        ata_wr_n     = !((state_q == S_STROBE) && kind_q.write);
        ata_d_oe     = kind_q.write &&
                       ((state_q == S_SETUP) || (state_q == S_STROBE) || hold_q);
        ata_d_o      = wdata_q;
        req_ready    = (state_q == S_IDLE);
        rsp_done     = done_q;
        rsp_err      = err_q;
        rsp_rdata    = rdata_q;
    end

endmodule

// File: rtl/ata_cycle_seq_chk.sv
module ata_cycle_seq_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ata_cmdsel_n,
    input logic              ata_ctlsel_n,
    input logic [ADDR_W-1:0] ata_reg_a,
    input logic              ata_rd_n,
    input logic              ata_wr_n,
    input logic              ata_dack_n,
    input logic              ata_d_oe,
    input logic              rsp_done,
    input logic              rsp_err
);

    AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_cmdsel_n && !ata_ctlsel_n) &&
        !(!ata_dack_n && (!ata_cmdsel_n || !ata_ctlsel_n))); // R2

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n)); // R3

    AST_STROBE_TARGETED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> (!ata_cmdsel_n || !ata_ctlsel_n || !ata_dack_n)); // R8

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> !ata_d_oe); // R5

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ata_cmdsel_n || !ata_ctlsel_n) && $past(!ata_cmdsel_n || !ata_ctlsel_n))
        |-> $stable(ata_reg_a)); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R4

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done); // R7

endmodule

bind ata_cycle_seq ata_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ata_cmdsel_n (ata_cmdsel_n),
    .ata_ctlsel_n (ata_ctlsel_n),
    .ata_reg_a    (ata_reg_a),
    .ata_rd_n     (ata_rd_n),
    .ata_wr_n     (ata_wr_n),
    .ata_dack_n   (ata_dack_n),
    .ata_d_oe     (ata_d_oe),
    .rsp_done     (rsp_done),
    .rsp_err      (rsp_err)
);

// File: tb/ata_cycle_seq_bench.sv
module ata_cycle_seq_bench;
    localparam int CW = 3;
    localparam int WW = 4;
    localparam int WL = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [CW-1:0] cfg_t1, cfg_t2, cfg_t2i;
    logic          req_valid, req_write, req_ctrl;
    logic [2:0]    req_addr;
    logic [15:0]   req_wdata;
    logic          req_ready;
    logic          dma_start, dma_write;
    logic [WW-1:0] dma_words;
    logic          rsp_done, rsp_err;
    logic [15:0]   rsp_rdata;
    logic          ata_cmdsel_n, ata_ctlsel_n, ata_rd_n, ata_wr_n, ata_dack_n;
    logic [2:0]    ata_reg_a;
    logic          ata_dreq, ata_ready;
    logic [15:0]   ata_d_i, ata_d_o;
    logic          ata_d_oe;

    ata_cycle_seq #(.DATA_W(16), .ADDR_W(3), .CNT_W(CW), .WORDS_W(WW),
                    .WAIT_LIMIT(WL), .SYNC_STAGES(2)) u_ata_cycle_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t2i(cfg_t2i),
        .req_valid(req_valid), .req_write(req_write), .req_ctrl(req_ctrl),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .dma_start(dma_start), .dma_write(dma_write), .dma_words(dma_words),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ata_cmdsel_n(ata_cmdsel_n), .ata_ctlsel_n(ata_ctlsel_n),
        .ata_reg_a(ata_reg_a), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
        .ata_dack_n(ata_dack_n), .ata_dreq(ata_dreq), .ata_ready(ata_ready),
        .ata_d_i(ata_d_i), .ata_d_o(ata_d_o), .ata_d_oe(ata_d_oe)
    );

    int total = 0;
    int bad   = 0;
    int stamp = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic set_cfg(input int a, input int b, input int c);
        cfg_t1 = CW'(a); cfg_t2 = CW'(b); cfg_t2i = CW'(c);
    endtask

    // One register cycle; rel < 0 keeps ready high, else ready is released in strobe cycle rel
    task automatic pio_cycle(input bit wr, input bit ctl, input int a, input int wd, input int rel);
        int ns = 0, nst = 0, nr = 0, noe = 0, bsel = 0, bda = 0, bkind = 0, bdat = 0;
        int last_dd = 0, k = 0, guard = 0, exp_st, lim, exp_err;
        bit seen = 0, strobe, got = 0;
        exp_st  = mx1(int'(cfg_t2));
        exp_err = 0;
        if (rel >= 0) begin
            ata_ready = 1'b0;
            repeat (3) @(negedge clk);
            lim    = mx1(int'(cfg_t2)) + WL - 1;
            exp_st = (rel + 3 > exp_st) ? rel + 3 : exp_st;
            if (exp_st > lim) begin exp_st = lim; exp_err = 1; end
        end
        req_valid = 1'b1; req_write = wr; req_ctrl = ctl;
        req_addr = 3'(a); req_wdata = 16'(wd);
        @(negedge clk);
        req_valid = 1'b0;
        while (guard < 200) begin
            guard++;
            if (rsp_done) begin got = 1; break; end
            if ((ctl ? (ata_ctlsel_n || !ata_cmdsel_n) : (ata_cmdsel_n || !ata_ctlsel_n)) || !ata_dack_n)
                bsel++;
            if (int'(ata_reg_a) != a) bda++;
            strobe = !ata_rd_n || !ata_wr_n;
            if (strobe) begin
                nst++; seen = 1;
                if (wr ? (ata_wr_n || !ata_rd_n) : (ata_rd_n || !ata_wr_n)) bkind++;
            end else if (!seen) ns++;
            else nr++;
            if (ata_d_oe) begin noe++; if (int'(ata_d_o) != wd) bdat++; end
            if (strobe) begin if (k == rel) ata_ready = 1'b1; k++; end
            stamp++;
            ata_d_i = 16'h5A00 ^ 16'(stamp * 37);
            if (strobe) last_dd = int'(ata_d_i);
            @(negedge clk);
        end
        chk("R4 done pulse seen", int'(got), 1);
        chk("R3 setup length", ns, mx1(int'(cfg_t1)));
        chk("R3 R6 R7 strobe length", nst, exp_st);
        chk("R3 recovery length", nr, mx1(int'(cfg_t2i)));
        chk("R3 strobe kind", bkind, 0);
        chk("R2 block select", bsel, 0);
        chk("R2 offset held", bda, 0);
        chk("R5 enable cycles", noe, wr ? (mx1(int'(cfg_t1)) + exp_st + 1) : 0);
        chk("R5 write data", bdat, 0);
        chk("R2 select released at done", int'(ata_cmdsel_n && ata_ctlsel_n), 1);
        chk("R7 error flag", int'(rsp_err), exp_err);
        if (!wr) chk("R4 read data", int'(rsp_rdata), last_dd);
        @(negedge clk);
        chk("R4 done one cycle", int'(rsp_done), 0);
        ata_ready = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic dma_burst(input bit wr, input int n, input bit pause);
        int bwait = 0, dones = 0, nstb = 0, bcs = 0, brd = 0, bdat = 0, bpause = 0;
        int bkind = 0, bdack = 0, last_dd = 0, guard = 0;
        bit prev = 0, strobe;
        ata_dreq = 1'b0; dma_words = WW'(n); dma_write = wr;
        req_wdata = 16'hC000; dma_start = 1'b1;
        @(negedge clk);
        dma_start = 1'b0;
        repeat (4) begin
            if (ata_dack_n || !ata_rd_n || !ata_wr_n) bwait++;
            @(negedge clk);
        end
        chk("R9 waits for request with acknowledge low", bwait, 0);
        ata_dreq = 1'b1;
        while (guard < 400) begin
            guard++;
            strobe = !ata_rd_n || !ata_wr_n;
            if (!ata_cmdsel_n || !ata_ctlsel_n) bcs++;
            if (strobe && !prev) nstb++;
            if (strobe && (wr ? ata_wr_n : ata_rd_n)) bkind++;
            prev = strobe;
            if (ata_d_oe && (int'(ata_d_o) != 16'hC000 + dones)) bdat++;
            if (rsp_done) begin
                dones++;
                if (!wr && int'(rsp_rdata) != last_dd) brd++;
                if (dones == n) break;
                if (ata_dack_n) bdack++;
                req_wdata = 16'(16'hC000 + dones);
                if (pause && dones == 1) begin
                    ata_dreq = 1'b0;
                    repeat (4) begin
                        @(negedge clk);
                        if (!ata_rd_n || !ata_wr_n || ata_dack_n) bpause++;
                    end
                    ata_dreq = 1'b1;
                end
            end else if (ata_dack_n) bdack++;
            stamp++;
            ata_d_i = 16'h3300 ^ 16'(stamp * 11);
            if (strobe) last_dd = int'(ata_d_i);
            @(negedge clk);
        end
        chk("R8 word count", dones, n);
        chk("R8 strobe count", nstb, n);
        chk("R8 selects stay high", bcs, 0);
        chk("R8 acknowledge held", bdack, 0);
        chk("R8 strobe kind", bkind, 0);
        chk("R8 acknowledge dropped at last done", int'(ata_dack_n), 1);
        if (!wr) chk("R8 R4 DMA read data", brd, 0);
        if (wr)  chk("R12 DMA write data per word", bdat, 0);
        if (pause) chk("R9 paused while request low", bpause, 0);
        ata_dreq = 1'b0;
        @(negedge clk);
        chk("R8 idle after burst", int'(req_ready && ata_dack_n), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_ctrl = 1'b0;
        req_addr = '0; req_wdata = '0; dma_start = 1'b0; dma_write = 1'b0;
        dma_words = '0; ata_dreq = 1'b0; ata_ready = 1'b1; ata_d_i = '0;
        set_cfg(1, 1, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 selects idle", int'(ata_cmdsel_n && ata_ctlsel_n), 1);
        chk("R1 strobes idle", int'(ata_rd_n && ata_wr_n && ata_dack_n), 1);
        chk("R1 enable and done low", int'(ata_d_oe || rsp_done), 0);
        chk("R1 ready high", int'(req_ready), 1);

        // R3 R4 R5 sweep of all phase counts
        for (int t1 = 0; t1 < 4; t1++)
            for (int t2 = 0; t2 < 4; t2++)
                for (int t3 = 0; t3 < 4; t3++) begin
                    set_cfg(t1, t2, t3);
                    pio_cycle(1'b0, 1'((t1 + t3) & 1), (t1 * 3 + t2 + t3) & 7, 0, -1);
                    pio_cycle(1'b1, 1'((t2 + t3) & 1), (t1 + t2 * 5 + t3) & 7,
                              16'h9000 + t1 * 16 + t2 * 4 + t3, -1);
                end

        // R6 R7 ready stretch and timeout sweep
        for (int t2 = 1; t2 < 4; t2++)
            for (int rel = 0; rel < 9; rel++) begin
                set_cfg(1, t2, 1);
                pio_cycle(1'(rel & 1), 1'(t2 & 1), rel & 7, 16'h7100 + rel, rel);
            end
        set_cfg(2, 2, 1);
        pio_cycle(1'b0, 1'b0, 6, 0, 100);

        // R8 R9 R12 DMA bursts
        set_cfg(1, 2, 1);
        dma_burst(1'b0, 1, 1'b0);
        dma_burst(1'b0, 4, 1'b1);
        dma_burst(1'b1, 5, 1'b1);
        set_cfg(0, 0, 0);
        dma_burst(1'b1, 3, 1'b0);

        // R10 zero-word start ignored
        begin
            int bz = 0;
            ata_dreq = 1'b1; dma_words = '0; dma_start = 1'b1;
            @(negedge clk);
            dma_start = 1'b0;
            repeat (6) begin
                if (!ata_dack_n || !ata_rd_n || !ata_wr_n || !req_ready) bz++;
                @(negedge clk);
            end
            chk("R10 zero count ignored", bz, 0);
            ata_dreq = 1'b0;
        end

        // R11 requests while busy, and register request priority
        begin
            int dn = 0, bda = 0, bdk = 0;
            set_cfg(3, 2, 2);
            ata_dreq = 1'b1;
            req_valid = 1'b1; req_write = 1'b0; req_ctrl = 1'b1; req_addr = 3'd2;
            dma_words = WW'(2); dma_start = 1'b1;
            @(negedge clk);
            req_addr = 3'd5;
            repeat (2) begin
                if (!ata_dack_n) bdk++;
                if (ata_reg_a != 3'd2) bda++;
                @(negedge clk);
            end
            req_valid = 1'b0; dma_start = 1'b0;
            repeat (20) begin
                if (rsp_done) dn++;
                if (!ata_dack_n) bdk++;
                if (!ata_ctlsel_n && ata_reg_a != 3'd2) bda++;
                @(negedge clk);
            end
            chk("R11 one cycle only", dn, 1);
            chk("R11 busy request ignored", bda, 0);
            chk("R11 register request wins", bdk, 0);
            ata_dreq = 1'b0;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule